// File: doc/BRIEF.md
# DMA Channel Priority and Error Register Bank

This block is the register-facing slice of a multi-channel DMA controller. It holds one bit per channel that selects high or default arbitration priority. Software can change that bit only through two aliases: one register sets bits where ones are written, and a second register clears bits where ones are written. A plain write of the mask itself is not possible, so read-modify-write races between software threads do not arise.

The block also records transfer faults for each channel. The engine reports a fault in one of two ways: a per-channel bus-error pulse, or a descriptor fetch whose 3-bit cycle-control field is zero. When a fault is captured, a sticky status bit is set and that channel's enable output is dropped. No other channel is affected. Software clears status bits by writing ones. An enable-set alias turns channels back on.

The bus is a simple strobe interface. A write takes effect at the clock edge where its strobe is sampled. A read returns registered data one cycle after its strobe.

Top module: `dma_prio_err_regs`

## Requirements
- R1: While `rst` is high at a clock edge, the priority mask, error status, channel enables and `bus_rdata` all become zero.
- R2: A write to offset 0x38 ORs `bus_wdata[13:0]` into the priority mask (zero bits leave their channel unchanged). A read of 0x38 returns the mask in bits [13:0].
- R3: A write to offset 0x3C clears every mask bit where `bus_wdata` holds a one, and leaves the other bits unchanged. A read of 0x3C returns zero.
- R4: A one on `bus_err[c]` sets error bit c at that clock edge.
- R5: When `desc_valid` is high and `desc_cc` equals 3'b000, error bit `desc_ch` is set. Any nonzero `desc_cc` sets nothing.
- R6: A captured fault clears `ch_enable[c]` for the faulting channel only. The enables of all other channels keep their values.
- R7: A write to offset 0x4C clears the error bits where `bus_wdata` holds a one, and zero bits have no effect. A read of 0x4C returns the error bits.
- R8: If a fault and a clearing write hit the same error bit in the same cycle, the bit ends up set.
- R9: A write to offset 0x20 ORs `bus_wdata[13:0]` into the channel enables, and a read of 0x20 returns them. A fault in the same cycle leaves that channel disabled.
- R10: Read data bits [31:14] are always zero. Reads of any other offset return zero. Writes to any other offset change no state.
- R11: Write effects are visible on the outputs after the sampling edge. `bus_rdata` holds the value selected by a read one cycle after `bus_rd`, and holds zero after a cycle with no read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 12 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | input | 14 | Per-channel bus-error pulses from the engine |
| desc_valid | input | 1 | A descriptor fetch completed this cycle |
| desc_ch | input | 4 | Channel of the fetched descriptor |
| desc_cc | input | 3 | Cycle-control field of the fetched descriptor |
| prio_mask | output | 14 | High-priority mask, one bit per channel |
| ch_enable | output | 14 | Channel enable, one bit per channel |

## Verification
On every cycle, the assertions check the following: the set and clear aliases move the mask exactly as requested, every fault source lands in the status, a fault drops only its own channel's enable, a fault beats a same-cycle clear, reset zeroes all state, and the reserved read bits stay zero. Some behaviours need the bench's scenarios and its cycle-accurate reference model: that nonzero cycle-control values are harmless, that unmapped writes leave all state untouched, that the clear alias reads as zero, and that reads return the right register with one cycle of latency.

// File: rtl/dma_reg_pkg.sv
package dma_reg_pkg;
  localparam logic [11:0] OFS_EN_SET   = 12'h020;
  localparam logic [11:0] OFS_PRIO_SET = 12'h038;
  localparam logic [11:0] OFS_PRIO_CLR = 12'h03C;
  localparam logic [11:0] OFS_ERR      = 12'h04C;

  typedef struct packed {
    logic en_set;
    logic prio_set;
    logic prio_clr;
    logic err;
  } reg_sel_t;
endpackage

// File: rtl/dma_addr_decode.sv
module dma_addr_decode
  import dma_reg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_t          sel
);
  always_comb begin
    sel.en_set   = (addr == ADDR_W'(OFS_EN_SET));
    sel.prio_set = (addr == ADDR_W'(OFS_PRIO_SET));
    sel.prio_clr = (addr == ADDR_W'(OFS_PRIO_CLR));
    sel.err      = (addr == ADDR_W'(OFS_ERR));
  end
endmodule

// File: rtl/dma_prio_mask.sv
module dma_prio_mask #(
  parameter int NUM_CH = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              set_we,
  input  logic              clr_we,
  input  logic [NUM_CH-1:0] wbits,
  output logic [NUM_CH-1:0] mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mask <= '0;
    end else if (set_we) begin
      mask <= mask | wbits;
    end else if (clr_we) begin
      mask <= mask & ~wbits;
    end
  end
endmodule

// File: rtl/dma_err_track.sv
module dma_err_track #(
  parameter int NUM_CH = 14,
  parameter int CH_W   = $clog2(NUM_CH),
  parameter int CC_W   = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] bus_err,
  input  logic              desc_valid,
  input  logic [CH_W-1:0]   desc_ch,
  input  logic [CC_W-1:0]   desc_cc,
  input  logic              clr_we,
  input  logic              en_we,
  input  logic [NUM_CH-1:0] wbits,
  output logic [NUM_CH-1:0] err_q,
  output logic [NUM_CH-1:0] enable_q
);
  logic bad_desc;
  assign bad_desc = desc_valid && (desc_cc == '0);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic fault;
    assign fault = bus_err[c] || (bad_desc && (desc_ch == CH_W'(c)));

    always_ff @(posedge clk) begin
      if (rst) begin
        err_q[c]    <= 1'b0;
        enable_q[c] <= 1'b0;
      end else begin
        if (fault)                     err_q[c] <= 1'b1;
        else if (clr_we && wbits[c])   err_q[c] <= 1'b0;
        if (fault)                     enable_q[c] <= 1'b0;
        else if (en_we && wbits[c])    enable_q[c] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_prio_err_regs.sv
module dma_prio_err_regs
  import dma_reg_pkg::*;
#(
  parameter int NUM_CH = 14,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CC_W   = 3,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NUM_CH-1:0] bus_err,
  input  logic              desc_valid,
  input  logic [CH_W-1:0]   desc_ch,
  input  logic [CC_W-1:0]   desc_cc,
  output logic [NUM_CH-1:0] prio_mask,
  output logic [NUM_CH-1:0] ch_enable
);
  localparam int PAD_W = DATA_W - NUM_CH;

  reg_sel_t          sel;
  logic [NUM_CH-1:0] wbits;
  logic [NUM_CH-1:0] err_q;
  logic [NUM_CH-1:0] rd_sel;
  logic              unused_hi;

  assign wbits     = bus_wdata[NUM_CH-1:0];
  assign unused_hi = ^bus_wdata[DATA_W-1:NUM_CH];

  dma_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  dma_prio_mask #(.NUM_CH(NUM_CH)) u_prio (
    .clk    (clk),
    .rst    (rst),
    .set_we (bus_wr && sel.prio_set),
    .clr_we (bus_wr && sel.prio_clr),
    .wbits  (wbits),
    .mask   (prio_mask)
  );

  dma_err_track #(.NUM_CH(NUM_CH), .CH_W(CH_W), .CC_W(CC_W)) u_err (
    .clk        (clk),
    .rst        (rst),
    .bus_err    (bus_err),
    .desc_valid (desc_valid),
    .desc_ch    (desc_ch),
    .desc_cc    (desc_cc),
    .clr_we     (bus_wr && sel.err),
    .en_we      (bus_wr && sel.en_set),
    .wbits      (wbits),
    .err_q      (err_q),
    .enable_q   (ch_enable)
  );

  always_comb begin
    rd_sel = '0;
    if (sel.prio_set) rd_sel = prio_mask;
    if (sel.err)      rd_sel = err_q;
    if (sel.en_set)   rd_sel = ch_enable;
  end

  always_ff @(posedge clk) begin
    if (rst || !bus_rd) bus_rdata <= '0;
    else                bus_rdata <= {{PAD_W{1'b0}}, rd_sel};
  end
endmodule

// File: rtl/dma_prio_err_chk.sv
module dma_prio_err_chk #(
  parameter int NUM_CH = 14,
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CH_W   = 4,
  parameter int CC_W   = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NUM_CH-1:0] wbits,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] bus_err,
  input logic              desc_valid,
  input logic [CH_W-1:0]   desc_ch,
  input logic [CC_W-1:0]   desc_cc,
  input logic [NUM_CH-1:0] prio_mask,
  input logic [NUM_CH-1:0] ch_enable,
  input logic [NUM_CH-1:0] err_q
);
  logic [NUM_CH-1:0] desc_hit;
  logic              wr_set, wr_clr, wr_err;
  always_comb begin
    desc_hit = '0;
    if (desc_valid && desc_cc == '0 && int'(desc_ch) < NUM_CH)
      desc_hit[desc_ch] = 1'b1;
  end
  assign wr_set = bus_wr && bus_addr == ADDR_W'(12'h038);
  assign wr_clr = bus_wr && bus_addr == ADDR_W'(12'h03C);
  assign wr_err = bus_wr && bus_addr == ADDR_W'(12'h04C);

  // R1
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (prio_mask == '0 && ch_enable == '0 && err_q == '0 && bus_rdata == '0));

  // R2
  prio_set_or_chk: assert property (@(posedge clk) disable iff (rst)
    wr_set |=> prio_mask == ($past(prio_mask) | $past(wbits)));

  // R3
  prio_clr_and_chk: assert property (@(posedge clk) disable iff (rst)
    wr_clr |=> prio_mask == ($past(prio_mask) & ~$past(wbits)));

  // R4
  bus_err_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_err != '0) |=> ((err_q & $past(bus_err)) == $past(bus_err)));

  // R5
  desc_err_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (desc_hit != '0) |=> ((err_q & $past(desc_hit)) == $past(desc_hit)));

  // R6
  fault_disables_chk: assert property (@(posedge clk) disable iff (rst)
    ((bus_err | desc_hit) != '0) |=> ((ch_enable & $past(bus_err | desc_hit)) == '0));

  // R8
  set_beats_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_err && ((bus_err | desc_hit) & wbits) != '0)
      |=> ((err_q & $past((bus_err | desc_hit) & wbits)) == $past((bus_err | desc_hit) & wbits)));

  // R10
  always @(negedge clk) begin
    if (!rst) reserved_zero_chk: assert (bus_rdata[DATA_W-1:NUM_CH] == '0);
  end
endmodule

bind dma_prio_err_regs dma_prio_err_chk #(
  .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .CC_W(CC_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .wbits      (bus_wdata[NUM_CH-1:0]),
  .bus_rdata  (bus_rdata),
  .bus_err    (bus_err),
  .desc_valid (desc_valid),
  .desc_ch    (desc_ch),
  .desc_cc    (desc_cc),
  .prio_mask  (prio_mask),
  .ch_enable  (ch_enable),
  .err_q      (err_q)
);

// File: tb/tb_dma_prio_err_regs.sv
module tb_dma_prio_err_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [13:0] bus_err = '0;
  logic        desc_valid = 1'b0;
  logic [3:0]  desc_ch = '0;
  logic [2:0]  desc_cc = '0;
  logic [13:0] prio_mask, ch_enable;

  int total = 0, bad = 0, cycles = 0;
  bit started = 0;

  always #2.5 clk = ~clk;

  dma_prio_err_regs dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
    .desc_valid(desc_valid), .desc_ch(desc_ch), .desc_cc(desc_cc),
    .prio_mask(prio_mask), .ch_enable(ch_enable)
  );

  // behavioural reference model
  bit [13:0] m_prio, m_err, m_en, ev;
  bit [31:0] m_rd;
  always @(posedge clk) begin
    if (rst) begin
      m_prio = 0; m_err = 0; m_en = 0; m_rd = 0;
    end else begin
      m_rd = 0;
      if (bus_rd) begin
        case (bus_addr)
          12'h038: m_rd = {18'd0, m_prio};
          12'h04C: m_rd = {18'd0, m_err};
          12'h020: m_rd = {18'd0, m_en};
          default: m_rd = 0;
        endcase
      end
      ev = bus_err;
      if (desc_valid && desc_cc == 0 && desc_ch < 14) ev[desc_ch] = 1;
      if (bus_wr) begin
        case (bus_addr)
          12'h038: m_prio = m_prio | bus_wdata[13:0];
          12'h03C: m_prio = m_prio & ~bus_wdata[13:0];
          12'h04C: m_err  = m_err & ~bus_wdata[13:0];
          12'h020: m_en   = m_en | bus_wdata[13:0];
          default: ;
        endcase
      end
      m_err = m_err | ev;
      m_en  = m_en & ~ev;
    end
  end

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // per-clock comparison against the model (R11 timing included)
  always @(negedge clk) begin
    if (started) begin
      check("R2/R3 prio_mask", {18'd0, prio_mask}, {18'd0, m_prio});
      check("R6/R9 ch_enable", {18'd0, ch_enable}, {18'd0, m_en});
      check("R11 bus_rdata", bus_rdata, m_rd);
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0; bus_wdata = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
    bus_rd = 0;
  endtask

  logic [31:0] r;

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; started = 1;
    // R1
    check("R1 prio reset", {18'd0, prio_mask}, 0);
    check("R1 enable reset", {18'd0, ch_enable}, 0);
    rd(12'h04C, r); check("R1 err reset", r, 0);

    // R2
    wr(12'h038, 32'h0000_0005);
    wr(12'h038, 32'hFFFF_2000);
    check("R2 set ORs", {18'd0, prio_mask}, 32'h2005);
    wr(12'h038, 32'h0);
    rd(12'h038, r); check("R2 read mask, R10 reserved", r, 32'h2005);

    // R3
    wr(12'h03C, 32'h0000_0001);
    check("R3 clear", {18'd0, prio_mask}, 32'h2004);
    rd(12'h03C, r); check("R3 reads zero", r, 0);

    // R9
    wr(12'h020, 32'h0000_3FFF);
    rd(12'h020, r); check("R9 enable readback", r, 32'h3FFF);

    // R4, R6
    bus_err = 14'h0008; @(negedge clk); bus_err = 0;
    check("R6 only ch3 disabled", {18'd0, ch_enable}, 32'h3FF7);
    rd(12'h04C, r); check("R4 bus error captured", r, 32'h0008);

    // R5
    desc_valid = 1; desc_ch = 13; desc_cc = 3'b000; @(negedge clk);
    desc_ch = 5; desc_cc = 3'b011; @(negedge clk); desc_valid = 0;
    rd(12'h04C, r); check("R5 invalid descriptor only", r, 32'h2008);
    check("R5/R6 enable after desc", {18'd0, ch_enable}, 32'h1FF7);

    // R7
    wr(12'h04C, 32'h0);
    rd(12'h04C, r); check("R7 zero write no effect", r, 32'h2008);
    wr(12'h04C, 32'h0000_0008);
    rd(12'h04C, r); check("R7 w1c", r, 32'h2000);

    // R8
    bus_err = 14'h0080; bus_wr = 1; bus_addr = 12'h04C; bus_wdata = 32'h2080;
    @(negedge clk); bus_err = 0; bus_wr = 0;
    rd(12'h04C, r); check("R8 set beats clear", r, 32'h0080);

    // R9 fault beats enable-set
    bus_err = 14'h0100; bus_wr = 1; bus_addr = 12'h020; bus_wdata = 32'h0100;
    @(negedge clk); bus_err = 0; bus_wr = 0;
    check("R9 fault wins over enable", {18'd0, ch_enable} & 32'h0100, 0);

    // R10
    wr(12'h040, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    check("R10 unmapped prio", {18'd0, prio_mask}, 32'h2004);
    rd(12'h040, r); check("R10 unmapped read", r, 0);
    rd(12'h04C, r); check("R10 err untouched", r, 32'h0180);

    // R11 no read -> zero
    @(negedge clk); check("R11 idle rdata", bus_rdata, 0);

    // R1 again
    rst = 1; @(negedge clk); rst = 0;
    check("R1 re-reset", {18'd0, prio_mask | ch_enable}, 0);
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected<20000", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end
endmodule